// File: doc/BRIEF.md
# Fractional baud generator

This block turns a base clock enable into a 16x oversampling tick for a serial line. Each enabled base cycle goes first through a fractional stage that lets through `mul` of every `mul + add` enabled cycles, evenly spread by an accumulator. The pulses that get through then feed a 16-bit integer divisor that emits one tick per `dl` pulses. The tick rate is therefore Fbase * mul / (mul + add) / dl, which is sixteen times the bit rate Fbase * mul / (mul + add) / (16 * dl).

Software programs the block through a small byte-wide write port. The divisor is held as two byte registers. These two registers accept writes only while a latch-access bit in a control register is set, the same way banked register maps share addresses with other functions. The multiplier and add value share one byte register. The port has no back-pressure: every write is taken in the cycle it is presented. The tick output is a plain one-cycle pulse.

Top module: `frac_baud_gen`

## Requirements
- R1: With base_en held high, the number of ticks seen in the first n enabled cycles after a restart is floor(floor(n*mul/(mul+add))/dl), where dl=0 counts as 65536.
- R2: With add=0, every enabled cycle passes the fractional stage, so ticks come exactly every dl enabled cycles.
- R3: Address 2 is the control register, and bit 0 of it is the latch-access bit. Address 0 (divisor bits 7:0) and address 1 (divisor bits 15:8) accept writes only while that bit is 1. A divisor write made while the bit is 0 changes neither the divisor nor the tick timing.
- R4: Address 3 holds the multiplier in bits 3:0 and the add value in bits 7:4. A write with mul=0 or add>=mul is ignored and the previous pair is kept.
- R5: A divisor of 0 acts as 65536: the first tick after the restart comes at enabled cycle 65536.
- R6: An accepted write to a divisor byte or to the fractional register clears the accumulator and reloads the counter, gives no tick in that cycle, and puts the first tick at enabled cycle ceil(dl*(mul+add)/mul) after it. A write to the control register does not restart.
- R7: While base_en is low, no tick is issued and the count does not advance. Progress resumes where it stopped.
- R8: tick_o is high for one clock cycle per tick. When dl is not 1, it is never high in two cycles in a row.
- R9: After reset, tick_o is low, dl=1, mul=1, add=0 and the access bit is 0, so each enabled cycle gives a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | Base clock enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0,1 divisor bytes, 2 control, 3 fractional) |
| wr_data | input | 8 | Register write data |
| tick_o | output | 1 | 16x oversampling tick, one cycle wide |

## Verification
A wrong accumulator value shows up as a tick count that drifts from floor(n*mul/(mul+add))/dl. Over windows of a few hundred cycles the drift is a whole tick or more. A counter that reloads wrongly moves the first tick after a restart, and that is visible within one divisor period. A leaked divisor write or a fractional pair that was wrongly accepted changes the first-tick position at the next restart.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DATA_W = 8;   // write-port byte width
  localparam int FRAC_W = 4;   // multiplier / add field width
  localparam int DIV_W  = 16;  // integer divisor width
  localparam int ADDR_W = 3;   // write-port address width

  // A fractional pair is usable only with mul > 0 and add < mul.
  function automatic logic frac_legal(input logic [FRAC_W-1:0] m,
                                      input logic [FRAC_W-1:0] a);
    return (m != '0) && (a < m);
  endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int FW  = FRAC_W,
  parameter int VW  = DIV_W,
  parameter int AW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          access_o,
  output logic [VW-1:0] dl_o,
  output logic [VW-1:0] dl_nx_o,
  output logic [FW-1:0] mul_o,
  output logic [FW-1:0] add_o,
  output logic [FW-1:0] mul_nx_o,
  output logic [FW-1:0] add_nx_o,
  output logic          restart_o
);
  localparam int NBYTES    = VW / DW;
  localparam int CTRL_ADDR = NBYTES;
  localparam int FRAC_ADDR = NBYTES + 1;
  localparam logic [VW-1:0] DL_RST = VW'(1);

  logic [NBYTES-1:0] lane_hit;
  logic [VW-1:0]     dl_q;
  logic              access_q;
  logic [FW-1:0]     mul_q, add_q;
  logic [FW-1:0]     wr_mul, wr_add;
  logic              frac_hit, ctrl_hit;

  // One write-enabled byte lane per divisor byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_hit[g] = wr_en && access_q && (wr_addr == AW'(g));
    assign dl_nx_o[g*DW +: DW] = lane_hit[g] ? wr_data : dl_q[g*DW +: DW];

    always_ff @(posedge clk) begin
      if (!rst_n)           dl_q[g*DW +: DW] <= DL_RST[g*DW +: DW];
      else if (lane_hit[g]) dl_q[g*DW +: DW] <= wr_data;
    end
  end

  assign wr_mul   = wr_data[FW-1:0];
  assign wr_add   = wr_data[2*FW-1:FW];
  assign ctrl_hit = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign frac_hit = wr_en && (wr_addr == AW'(FRAC_ADDR)) && frac_legal(wr_mul, wr_add);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_q <= 1'b0;
      mul_q    <= FW'(1);
      add_q    <= '0;
    end else begin
      if (ctrl_hit) access_q <= wr_data[0];
      if (frac_hit) begin
        mul_q <= wr_mul;
        add_q <= wr_add;
      end
    end
  end

  assign mul_nx_o  = frac_hit ? wr_mul : mul_q;
  assign add_nx_o  = frac_hit ? wr_add : add_q;
  assign restart_o = (|lane_hit) || frac_hit;
  assign access_o  = access_q;
  assign dl_o      = dl_q;
  assign mul_o     = mul_q;
  assign add_o     = add_q;
endmodule

// File: rtl/fbg_frac.sv
module fbg_frac #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic [FW-1:0] mul_i,
  input  logic [FW-1:0] add_i,
  output logic          step_o
);
  // accumulator stays below mul+add < 2^(FW+1); the sum needs one more bit
  localparam int AW = FW + 2;

  logic [AW-1:0] acc_q, sum, den;

  assign sum    = acc_q + AW'(mul_i);
  assign den    = AW'(mul_i) + AW'(add_i);
  assign step_o = en_i && !restart_i && (sum >= den);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) acc_q <= '0;
    else if (en_i)           acc_q <= step_o ? (sum - den) : sum;
  end
endmodule

// File: rtl/fbg_intdiv.sv
module fbg_intdiv #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic [VW-1:0] dl_i,
  input  logic [VW-1:0] dl_nx_i,
  output logic [VW-1:0] cnt_o,
  output logic          tick_o
);
  // dl - 1 wraps a divisor of 0 to all ones, giving a period of 2^VW
  logic [VW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= dl_nx_i - VW'(1);
      tick_q <= 1'b0;
    end else begin
      tick_q <= step_i && (cnt_q == '0);
      if (step_i) cnt_q <= (cnt_q == '0) ? (dl_i - VW'(1)) : (cnt_q - VW'(1));
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W,
  parameter int VW = DIV_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          tick_o
);
  logic          access_q, restart, frac_step;
  logic [VW-1:0] dl_q, dl_nx, cnt_q;
  logic [FW-1:0] mul_q, add_q, mul_nx, add_nx;

  fbg_regs #(.DW(DW), .FW(FW), .VW(VW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .access_o (access_q),
    .dl_o     (dl_q),
    .dl_nx_o  (dl_nx),
    .mul_o    (mul_q),
    .add_o    (add_q),
    .mul_nx_o (mul_nx),
    .add_nx_o (add_nx),
    .restart_o(restart)
  );

  fbg_frac #(.FW(FW)) u_frac (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (base_en),
    .restart_i(restart),
    .mul_i    (mul_q),
    .add_i    (add_q),
    .step_o   (frac_step)
  );

  fbg_intdiv #(.VW(VW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (frac_step),
    .restart_i(restart),
    .dl_i     (dl_q),
    .dl_nx_i  (dl_nx),
    .cnt_o    (cnt_q),
    .tick_o   (tick_o)
  );

  // next-cycle fractional values are consumed by the checker only
  logic unused_nx;
  assign unused_nx = ^{mul_nx, add_nx};
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int FW = 4,
  parameter int VW = 16,
  parameter int AW = 3,
  parameter int NBYTES = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          base_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          tick,
  input logic          access,
  input logic          restart,
  input logic          frac_step,
  input logic [VW-1:0] dl,
  input logic [VW-1:0] cnt,
  input logic [FW-1:0] mul,
  input logic [FW-1:0] add,
  input logic          unused_nx
);
  logic unused_ok;
  assign unused_ok = unused_nx;

  p_tick_after_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(base_en));

  p_locked_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !access && (wr_addr < AW'(NBYTES))) |=> $stable(dl));

  p_frac_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mul != '0) && (add < mul));

  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= VW'(dl - VW'(1)));

  p_unit_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_en && (add == '0) && !restart) |-> frac_step);

  p_no_back2back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (dl != VW'(1))) |=> !tick);
endmodule

bind frac_baud_gen fbg_checker #(.FW(FW), .VW(VW), .AW(AW), .NBYTES(VW/DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_en  (base_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .tick     (tick_o),
  .access   (access_q),
  .restart  (restart),
  .frac_step(frac_step),
  .dl       (dl_q),
  .cnt      (cnt_q),
  .mul      (mul_q),
  .add      (add_q),
  .unused_nx(unused_nx)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick_o(tick_o)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic longint exp_cnt(longint n, longint m, longint a, longint d);
    longint dv = (d == 0) ? 65536 : d;
    return ((n * m) / (m + a)) / dv;
  endfunction

  function automatic longint exp_first(longint m, longint a, longint d);
    longint dv = (d == 0) ? 65536 : d;
    return (dv * (m + a) + m - 1) / m;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; base_en = 1'b1;
    @(posedge clk); #1;
  endtask

  // runs k cycles; alt drives base_en high only on even cycles
  task automatic run(input int k, input bit alt, output int cnt, output int first,
                     output int nen, output bit b2b);
    bit prev = 1'b0;
    cnt = 0; first = -1; nen = 0; b2b = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      base_en = alt ? (i % 2 == 0) : 1'b1;
      @(posedge clk); #1;
      if (base_en) nen++;
      if (tick_o) begin
        cnt++;
        if (first < 0) first = nen;
        if (prev) b2b = 1'b1;
      end
      prev = tick_o;
    end
  endtask

  task automatic t_reset();
    int c, f, n; bit b;
    check("R9 tick low in reset", tick_o, 0);
    @(negedge clk); rst_n = 1'b1; base_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (tick_o) c++;
    end
    check("R7 no tick while base_en low", c, 0);
    run(8, 1'b0, c, f, n, b);
    check("R9 default tick every enabled cycle", c, 8);
    check("R9 default first tick", f, 1);
  endtask

  task automatic t_integer();
    int c, f, n; bit b;
    wr(3'd2, 8'h01);
    wr(3'd0, 8'd5);
    check("R6 no tick in restart cycle", tick_o, 0);
    wr(3'd1, 8'd0);
    run(40, 1'b0, c, f, n, b);
    check("R2 integer period count", c, 8);
    check("R2 integer first tick", f, 5);
    check("R8 no back-to-back ticks", b, 0);
  endtask

  task automatic t_fraction();
    int c, f, n; bit b;
    wr(3'd0, 8'd4);
    wr(3'd3, 8'h23);
    run(200, 1'b0, c, f, n, b);
    check("R1 frac 3/5 dl4 count", c, exp_cnt(200, 3, 2, 4));
    check("R6 frac 3/5 dl4 first", f, exp_first(3, 2, 4));
    wr(3'd0, 8'd3);
    wr(3'd3, 8'hEF);
    run(290, 1'b0, c, f, n, b);
    check("R1 frac 15/29 dl3 count", c, exp_cnt(290, 15, 14, 3));
    check("R4 frac 15/29 dl3 first", f, exp_first(15, 14, 3));
    wr(3'd0, 8'd2);
    wr(3'd3, 8'h27);
    run(300, 1'b1, c, f, n, b);
    check("R7 gated enable count", c, exp_cnt(n, 7, 2, 2));
    check("R7 gated enabled cycles", n, 150);
  endtask

  task automatic t_lock();
    int c, f, n; bit b;
    wr(3'd0, 8'd9);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'd2);
    wr(3'd1, 8'd1);
    wr(3'd3, 8'h01);
    run(30, 1'b0, c, f, n, b);
    check("R3 locked divisor count", c, 3);
    check("R3 locked divisor first", f, 9);
  endtask

  task automatic t_badfrac();
    int c, f, n; bit b;
    wr(3'd3, 8'h12);
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h55);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'd3);
    run(60, 1'b0, c, f, n, b);
    check("R4 illegal pair ignored count", c, exp_cnt(60, 2, 1, 3));
    check("R4 illegal pair ignored first", f, exp_first(2, 1, 3));
  endtask

  task automatic t_reload();
    int c, f, n; bit b;
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h03);
    wr(3'd0, 8'hE8);
    run(20, 1'b0, c, f, n, b);
    check("R6 no tick early in long period", c, 0);
    wr(3'd1, 8'h00);
    run(300, 1'b0, c, f, n, b);
    check("R6 first tick after reload", f, 232);
  endtask

  task automatic t_zero();
    int c, f, n; bit b;
    wr(3'd0, 8'h00);
    run(65536, 1'b0, c, f, n, b);
    check("R5 zero divisor count", c, 1);
    check("R5 zero divisor first", f, 65536);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_integer();
    t_fraction();
    t_lock();
    t_badfrac();
    t_reload();
    t_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule